// File: doc/BRIEF.md
# Block-Protocol SMBus Control Register Slave

This block is the serial control port of a clock generator. It listens on the two-wire SMBus lines (SCL, and SDA with an open-drain output), answers one 7-bit address picked by an address strap latched at reset, and gives access to eight byte-wide control registers. Every transfer uses the indexed block protocol. A write carries a register offset, then a byte count N, then N data bytes that land in consecutive registers. A read carries the offset, then a repeated start with the read address. The slave then returns a byte count followed by data from consecutive registers until the master answers with a NACK. The register fields drive the clock control logic: per-output enables, spread-spectrum software control, amplitude code, per-output slew selects and the reference-output controls. The two spread strap bits come in from outside and read back as read-only bits.

SCL and SDA are oversampled on the system clock through a synchronizer. A protocol state machine has these states:
- IDLE: no transfer.
- ADDR, OFFS, COUNT, WDATA: receive a byte, one state per byte role.
- ACK: the slave holds SDA low for one bit.
- TX: the slave shifts a byte out.
- TX_ACK: the slave samples the master's acknowledge.
- HOLD: the slave ignores the bus until the next start or stop.

Transitions:
- A start condition in any state moves to ADDR.
- A stop condition in any state moves to IDLE.
- At the end of a received byte (the SCL fall after the eighth rising edge), the machine goes to ACK if the byte is accepted and to HOLD if it is refused.
- ACK moves, on the next SCL fall, to the byte's successor:
  - ADDR with the write bit goes to OFFS.
  - ADDR with the read bit goes to TX.
  - OFFS goes to COUNT.
  - COUNT goes to WDATA.
  - WDATA goes back to WDATA.
- TX goes to TX_ACK after eight bits.
- TX_ACK goes back to TX on a master ACK and to HOLD on a master NACK.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The slave address is 7'b1101000 when the strap sampled during reset is 0, and 7'b1101010 when it is 1. A matching address byte is acknowledged. A non-matching one is not acknowledged, and the slave leaves SDA released until the next start condition.
- R2: In a write, the offset byte and a nonzero count byte N are acknowledged. Each of the following N data bytes is acknowledged and stored in consecutive registers, starting at the offset.
- R3: A write count byte of zero is not acknowledged, and no register changes.
- R4: A data byte sent after the N counted bytes of a write is not acknowledged and is not stored.
- R5: After a repeated start with the read bit, the slave sends the byte count first. It then sends registers from the offset upward, one byte after each master ACK, and stops driving once the master NACKs.
- R6: Only the low three bits of the offset select the register. The register pointer wraps from register 7 to register 0 in both reads and writes.
- R7: Register 0 bits [3:0] are the four output enables (reset 1, writable) and drive out_en_o. Bits [7:4] read 1 and ignore writes.
- R8: Register 1 has these fields:
  - Bits [7:6] read the spread strap input spread_rb_i and are read-only.
  - Bit 5 is the software spread enable, reset 0.
  - Bits [4:3] are the software spread code, reset 00.
  - Bit 2 reads 0.
  - Bits [1:0] are the amplitude code, reset 10.
  - The writable fields drive their outputs.
- R9: Register 2 bits [3:0] are the per-output slew selects (reset 1111), and bits [7:4] read 1. Register 3 has these fields:
  - Bits [7:6] are the reference slew code, reset 01.
  - Bit 5 is the wake enable, reset 0.
  - Bit 4 is the reference enable, reset 1.
  - Bits [3:0] read 1.
- R10: Registers 4, 5 and 6 are read-only and read 8'hFF, 8'h00 and 8'h04. Writes to them are acknowledged and have no effect.
- R11: Register 7 holds the read byte count. It resets to 8, is fully writable, and its value is the first byte of every read.
- R12: A stop after any complete byte ends the transfer and keeps the bytes already stored. The slave changes SDA only while SCL is low, and SDA is released after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; the address strap is sampled while it is low |
| addr_strap_i | input | 1 | Address select strap |
| spread_rb_i | input | 2 | Spread strap readback bits |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| out_en_o | output | 4 | Per-output clock enables |
| ss_sw_en_o | output | 1 | Software spread control enable |
| ss_code_o | output | 2 | Software spread code |
| amp_code_o | output | 2 | Output amplitude code |
| slew_sel_o | output | 4 | Per-output slew select |
| ref_slew_o | output | 2 | Reference output slew code |
| ref_wake_o | output | 1 | Reference keeps running in power down |
| ref_en_o | output | 1 | Reference output enable |

## Verification
The bench builds the block with its default parameters: a two-stage line synchronizer and a base address of 7'h68. A bus quarter-bit of eight system clocks gives the slave's four-cycle response delay room inside each SCL low phase. Two resets, one with each strap value, bring both addresses and the refusal of the other address within reach. The bench also covers offsets above 7, a pointer that crosses register 7, a zero count, bytes beyond the count, and a stop part-way through a write.

// File: rtl/cfg_smbus_pkg.sv
package cfg_smbus_pkg;

    localparam int REG_COUNT = 8;
    localparam int IDX_W     = $clog2(REG_COUNT);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_OFFS,
        ST_COUNT,
        ST_WDATA,
        ST_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_HOLD
    } bus_state_t;

    // Bits that a bus write may change, per register.
    function automatic logic [7:0] write_mask(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 8'h0F;
            3'd1:    return 8'h3B;
            3'd2:    return 8'h0F;
            3'd3:    return 8'hF0;
            3'd7:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // Reset contents, per register.
    function automatic logic [7:0] reset_value(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 8'hFF;
            3'd1:    return 8'h02;
            3'd2:    return 8'hFF;
            3'd3:    return 8'h5F;
            3'd4:    return 8'hFF;
            3'd5:    return 8'h00;
            3'd6:    return 8'h04;
            default: return 8'h08;
        endcase
    endfunction

endpackage

// File: rtl/cfg_smbus_line_sync.sv
module cfg_smbus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("cfg_smbus_line_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfg_smbus_regs.sv
module cfg_smbus_regs
    import cfg_smbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [1:0]       spread_rb_i,
    output logic [7:0]       rd_data,
    output logic [7:0]       cnt_val,
    output logic [3:0]       out_en_o,
    output logic             ss_sw_en_o,
    output logic [1:0]       ss_code_o,
    output logic [1:0]       amp_code_o,
    output logic [3:0]       slew_sel_o,
    output logic [1:0]       ref_slew_o,
    output logic             ref_wake_o,
    output logic             ref_en_o
);

    logic [REG_COUNT-1:0][7:0] regs;

    generate
        for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
            localparam logic [7:0]       MASK   = write_mask(MY_IDX);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[i] <= reset_value(MY_IDX);
                end else if (wr_en && wr_idx == MY_IDX) begin
                    regs[i] <= (regs[i] & ~MASK) | (wr_data & MASK);
                end
            end

            // R10
            reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_idx == MY_IDX) |=> $stable(regs[i]))
                else $error("register %0d changed without a write", i);
        end
    endgenerate

    always_comb begin
        rd_data = regs[rd_idx];
        if (rd_idx == IDX_W'(1)) begin
            rd_data[7:6] = spread_rb_i;
        end
    end

    assign cnt_val    = regs[REG_COUNT-1];
    assign out_en_o   = regs[0][3:0];
    assign ss_sw_en_o = regs[1][5];
    assign ss_code_o  = regs[1][4:3];
    assign amp_code_o = regs[1][1:0];
    assign slew_sel_o = regs[2][3:0];
    assign ref_slew_o = regs[3][7:6];
    assign ref_wake_o = regs[3][5];
    assign ref_en_o   = regs[3][4];

endmodule

// File: rtl/cfg_smbus_engine.sv
module cfg_smbus_engine
    import cfg_smbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       dev_addr,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       cnt_val,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sda_oe
);

    bus_state_t       state, nxt, ack_next, target;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [7:0]       tx_sh;
    logic [7:0]       remain;
    logic [IDX_W-1:0] ptr;
    logic             ack_bit;
    logic             take;
    logic             byte_full;
    logic             rx_state;

    assign byte_full = (bit_cnt == 4'd8);
    assign rx_state  = (state == ST_ADDR) || (state == ST_OFFS) ||
                       (state == ST_COUNT) || (state == ST_WDATA);

    // Accept decision and successor for the byte just received.
    always_comb begin
        take   = 1'b0;
        target = ST_IDLE;
        unique case (state)
            ST_ADDR: begin
                take   = (shreg[7:1] == dev_addr);
                target = shreg[0] ? ST_TX : ST_OFFS;
            end
            ST_OFFS: begin
                take   = 1'b1;
                target = ST_COUNT;
            end
            ST_COUNT: begin
                take   = (shreg != 8'h00);
                target = ST_WDATA;
            end
            ST_WDATA: begin
                take   = (remain != 8'h00);
                target = ST_WDATA;
            end
            default: ;
        endcase
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_HOLD: ;
                ST_ADDR, ST_OFFS, ST_COUNT, ST_WDATA:
                    if (scl_fall && byte_full) nxt = take ? ST_ACK : ST_HOLD;
                ST_ACK:
                    if (scl_fall) nxt = ack_next;
                ST_TX:
                    if (scl_fall && byte_full) nxt = ST_TX_ACK;
                ST_TX_ACK:
                    if (scl_fall) nxt = ack_bit ? ST_HOLD : ST_TX;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack_next <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            tx_sh    <= '0;
            remain   <= '0;
            ptr      <= '0;
            ack_bit  <= 1'b1;
        end else begin
            state <= nxt;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else if (scl_rise) begin
                bit_cnt <= bit_cnt + 4'd1;
                shreg   <= {shreg[6:0], sda_s};
                if (state == ST_TX_ACK) ack_bit <= sda_s;
            end else if (scl_fall) begin
                if (byte_full || state == ST_ACK || state == ST_TX_ACK) bit_cnt <= '0;
                if (rx_state && byte_full) begin
                    if (take) ack_next <= target;
                    if (state == ST_OFFS) ptr <= shreg[IDX_W-1:0];
                    if (state == ST_COUNT) remain <= shreg;
                    if (state == ST_WDATA && take) begin
                        remain <= remain - 8'd1;
                        ptr    <= ptr + 1'b1;
                    end
                end
                if (state == ST_ACK && ack_next == ST_TX) tx_sh <= cnt_val;
                if (state == ST_TX && !byte_full) tx_sh <= {tx_sh[6:0], 1'b1};
                if (state == ST_TX_ACK && !ack_bit) begin
                    tx_sh <= rd_data;
                    ptr   <= ptr + 1'b1;
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        sda_oe  = (state == ST_ACK) || (state == ST_TX && !tx_sh[7]);
        wr_en   = (state == ST_WDATA) && scl_fall && byte_full && take &&
                  !start_det && !stop_det;
        wr_idx  = ptr;
        wr_data = shreg;
        rd_idx  = ptr;
    end

    // R12
    sda_quiet_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe))
        else $error("SDA drive moved while SCL high");

    // R3
    zero_count_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && scl_fall && byte_full && shreg == 8'h00 &&
         !start_det && !stop_det) |=> (state == ST_HOLD && !sda_oe))
        else $error("zero count was accepted");

    // R4
    no_write_past_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && remain == 8'h00) |-> !wr_en)
        else $error("write after count exhausted");

    // R1
    hold_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> !sda_oe)
        else $error("SDA driven while holding");

endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
    import cfg_smbus_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] BASE_ADDR   = 7'h68
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_strap_i,
    input  logic [1:0] spread_rb_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [3:0] out_en_o,
    output logic       ss_sw_en_o,
    output logic [1:0] ss_code_o,
    output logic [1:0] amp_code_o,
    output logic [3:0] slew_sel_o,
    output logic [1:0] ref_slew_o,
    output logic       ref_wake_o,
    output logic       ref_en_o
);

    logic             strap_q;
    logic [6:0]       dev_addr;
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data, cnt_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strap_q <= addr_strap_i;
    end

    assign dev_addr = BASE_ADDR | {5'b0, strap_q, 1'b0};

    cfg_smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_smbus_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_addr  (dev_addr),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .cnt_val   (cnt_val),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .sda_oe    (sda_oe_o)
    );

    cfg_smbus_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .rd_idx      (rd_idx),
        .spread_rb_i (spread_rb_i),
        .rd_data     (rd_data),
        .cnt_val     (cnt_val),
        .out_en_o    (out_en_o),
        .ss_sw_en_o  (ss_sw_en_o),
        .ss_code_o   (ss_code_o),
        .amp_code_o  (amp_code_o),
        .slew_sel_o  (slew_sel_o),
        .ref_slew_o  (ref_slew_o),
        .ref_wake_o  (ref_wake_o),
        .ref_en_o    (ref_en_o)
    );

endmodule

// File: tb/cfg_smbus_slave_tb.sv
module cfg_smbus_slave_tb;

    localparam int Q = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       strap = 1'b0;
    logic [1:0] rb = 2'b01;
    logic       scl_m = 1'b1;
    logic       sda_m_low = 1'b0;
    logic       sda_oe;
    logic [3:0] out_en, slew_sel;
    logic       ss_sw_en, ref_wake, ref_en;
    logic [1:0] ss_code, amp_code, ref_slew;
    logic       sda_bus;

    assign sda_bus = ~(sda_m_low | sda_oe);

    cfg_smbus_slave u_dut (
        .clk (clk), .rst_n (rst_n), .addr_strap_i (strap), .spread_rb_i (rb),
        .scl_i (scl_m), .sda_i (sda_bus), .sda_oe_o (sda_oe),
        .out_en_o (out_en), .ss_sw_en_o (ss_sw_en), .ss_code_o (ss_code),
        .amp_code_o (amp_code), .slew_sel_o (slew_sel), .ref_slew_o (ref_slew),
        .ref_wake_o (ref_wake), .ref_en_o (ref_en)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] model [8];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    string      tag_q [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pairs each byte the slave returned with its expectation.
    initial forever begin
        @(negedge clk);
        while (got_q.size() > 0 && exp_q.size() > 0)
            check(tag_q.pop_front(), {24'h0, got_q.pop_front()}, {24'h0, exp_q.pop_front()});
    end

    function automatic logic [7:0] mask_of(input int idx);
        case (idx)
            0: return 8'h0F;
            1: return 8'h3B;
            2: return 8'h0F;
            3: return 8'hF0;
            7: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0; strap = s; scl_m = 1'b1; sda_m_low = 1'b0;
        wait_q(5);
        rst_n = 1'b1;
        wait_q(5);
        model = '{8'hFF, {rb, 6'h02}, 8'hFF, 8'h5F, 8'hFF, 8'h00, 8'h04, 8'h08};
    endtask

    task automatic bus_start();
        sda_m_low = 1'b0; scl_m = 1'b1; wait_q(Q);
        sda_m_low = 1'b1; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_rstart();
        sda_m_low = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m_low = 1'b1; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m_low = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m_low = 1'b0; wait_q(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m_low = ~b; wait_q(Q);
        scl_m = 1'b1; wait_q(2 * Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m_low = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        b = sda_bus; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
    endtask

    // Address-only probe: start, address with write bit, stop.
    task automatic probe(input logic [6:0] a, input logic exp_ack, input string tag);
        logic ack;
        bus_start();
        put_byte({a, 1'b0}, ack);
        check(tag, {31'h0, ack}, {31'h0, exp_ack});
        bus_stop();
        check({tag, " sda released"}, {31'h0, sda_oe}, 32'h0);
    endtask

    // Indexed block write; nsend bytes offered against count cnt.
    task automatic wr_xfer(input logic [6:0] a, input logic [7:0] offs, input logic [7:0] cnt,
                           input int nsend, input logic [7:0] d [5], input string tag);
        logic ack;
        int   idx;
        bus_start();
        put_byte({a, 1'b0}, ack);
        check({tag, " R1 addr ack"}, {31'h0, ack}, 32'h1);
        put_byte(offs, ack);
        check({tag, " R2 offset ack"}, {31'h0, ack}, 32'h1);
        put_byte(cnt, ack);
        check({tag, " R3 count ack"}, {31'h0, ack}, {31'h0, cnt != 8'h00});
        if (cnt != 8'h00) begin
            for (int i = 0; i < nsend; i++) begin
                put_byte(d[i], ack);
                check({tag, " R4 data ack"}, {31'h0, ack}, {31'h0, i < int'(cnt)});
                if (i < int'(cnt)) begin
                    idx = (int'(offs[2:0]) + i) % 8;
                    model[idx] = (model[idx] & ~mask_of(idx)) | (d[i] & mask_of(idx));
                end
                if (!ack) break;
            end
        end
        bus_stop();
        check({tag, " R12 sda released"}, {31'h0, sda_oe}, 32'h0);
    endtask

    // Indexed block read of the count byte plus ndata data bytes.
    task automatic rd_xfer(input logic [6:0] a, input logic [7:0] offs, input int ndata,
                           input string tag);
        logic       ack;
        logic [7:0] d;
        bus_start();
        put_byte({a, 1'b0}, ack);
        check({tag, " R1 addr ack"}, {31'h0, ack}, 32'h1);
        put_byte(offs, ack);
        check({tag, " R5 offset ack"}, {31'h0, ack}, 32'h1);
        bus_rstart();
        put_byte({a, 1'b1}, ack);
        check({tag, " R5 read addr ack"}, {31'h0, ack}, 32'h1);
        exp_q.push_back(model[7]);
        tag_q.push_back({tag, " R11 count byte"});
        get_byte(1'b1, d);
        got_q.push_back(d);
        for (int i = 0; i < ndata; i++) begin
            exp_q.push_back(model[(int'(offs[2:0]) + i) % 8]);
            tag_q.push_back({tag, " R5 data byte"});
            get_byte(i != ndata - 1, d);
            got_q.push_back(d);
        end
        wait_q(2);
        check({tag, " R5 released after NACK"}, {31'h0, sda_oe}, 32'h0);
        bus_stop();
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " R7 out_en"},   {28'h0, out_en},   {28'h0, model[0][3:0]});
        check({tag, " R8 ss_sw_en"}, {31'h0, ss_sw_en}, {31'h0, model[1][5]});
        check({tag, " R8 ss_code"},  {30'h0, ss_code},  {30'h0, model[1][4:3]});
        check({tag, " R8 amp_code"}, {30'h0, amp_code}, {30'h0, model[1][1:0]});
        check({tag, " R9 slew_sel"}, {28'h0, slew_sel}, {28'h0, model[2][3:0]});
        check({tag, " R9 ref_slew"}, {30'h0, ref_slew}, {30'h0, model[3][7:6]});
        check({tag, " R9 ref_wake"}, {31'h0, ref_wake}, {31'h0, model[3][5]});
        check({tag, " R9 ref_en"},   {31'h0, ref_en},   {31'h0, model[3][4]});
    endtask

    initial begin
        do_reset(1'b0);
        check("R7 reset out_en", {28'h0, out_en}, 32'hF);
        check("R8 reset amp_code", {30'h0, amp_code}, 32'h2);
        check("R9 reset ref_slew", {30'h0, ref_slew}, 32'h1);
        check_outputs("reset");
        check("R12 reset sda idle", {31'h0, sda_oe}, 32'h0);

        // Full read of reset contents: count 8 then registers 0..7.
        rd_xfer(7'h68, 8'h00, 8, "full read");

        // R1: other address refused, then normal traffic resumes.
        probe(7'h6A, 1'b0, "R1 wrong address");
        probe(7'h68, 1'b1, "R1 own address");

        // R2, R7, R8: two-byte write at offset 0.
        wr_xfer(7'h68, 8'h00, 8'h02, 2, '{8'h05, 8'hFF, 8'h00, 8'h00, 8'h00}, "R2 write");
        check_outputs("R2 after write");

        // R4, R9, R10: four counted bytes from offset 2, a fifth is refused.
        wr_xfer(7'h68, 8'h02, 8'h04, 5, '{8'h00, 8'h00, 8'hAA, 8'h11, 8'h3C}, "R4 overrun");
        check_outputs("R9 after write");
        rd_xfer(7'h68, 8'h04, 3, "R10 read-only");

        // R3: zero count refused, nothing changes.
        wr_xfer(7'h68, 8'h01, 8'h00, 0, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, "R3 zero count");
        check_outputs("R3 unchanged");

        // R6, R11: write across the wrap, offset above 7, count register.
        wr_xfer(7'h68, 8'h07, 8'h02, 2, '{8'h03, 8'h0A, 8'h00, 8'h00, 8'h00}, "R6 wrap write");
        check_outputs("R6 after wrap");
        rd_xfer(7'h68, 8'h09, 4, "R6 high offset");
        rd_xfer(7'h68, 8'h07, 2, "R11 count reg");

        // R12: stop after one of three counted bytes.
        wr_xfer(7'h68, 8'h00, 8'h03, 1, '{8'h0C, 8'h00, 8'h00, 8'h00, 8'h00}, "R12 early stop");
        check_outputs("R12 after stop");
        rd_xfer(7'h68, 8'h00, 3, "R12 readback");

        // R1: strap 1 selects the other address.
        do_reset(1'b1);
        check_outputs("R1 strap reset");
        probe(7'h68, 1'b0, "R1 strap1 old address");
        rd_xfer(7'h6A, 8'h00, 8, "R1 strap1 read");

        wait_q(20);
        check("R5 scoreboard drained", exp_q.size(), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule